// File: doc/BRIEF.md
# Aliased Sub-Register File With Byte ALU

This block holds eight 32-bit general registers and executes one register-file operation per clock. The first four registers each expose three narrower views: their low 16 bits as a word, and that word's upper and lower bytes as two separate byte registers. The remaining four registers are normally used as pointers and index registers. They can be reached only as a full 32-bit value or as their low 16 bits.

An operation names a source and a destination, in that order. It can move an immediate or a register into a register at 8, 16 or 32-bit width. It can also add or subtract an immediate or a byte register into a byte register. A write narrower than 32 bits replaces only the field it names, and the rest of the containing register is kept. Two combinational read ports return whole registers. A request that names a byte view of a pointer register, or that is otherwise malformed, raises a flag and changes nothing.

Top module: `regalias_core`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A byte write (`op_size`=0) to register 0..3 replaces bits 15:8 when `dst_hi`=1 and bits 7:0 when `dst_hi`=0. All other bits of that register keep their value. An immediate byte takes `imm[7:0]`, so 54, 8'h36 and the character "6" give the same result.
- R3: A word write (`op_size`=1) replaces bits 15:0 of the destination and keeps bits 31:16.
- R4: A double-word write (`op_size`=2) replaces all 32 bits of the destination.
- R5: A move (`op_code`=0) with `op_imm`=0 copies the source field of the same width. For a byte source, that field is bits 15:8 of the source when `src_hi`=1 and bits 7:0 when `src_hi`=0. With `op_imm`=1 the move takes the low bits of `imm` instead.
- R6: A byte add (`op_code`=1) stores (destination byte + operand) mod 256. No carry reaches any other bit.
- R7: A byte subtract (`op_code`=2) stores (destination byte - operand) mod 256. No borrow reaches any other bit.
- R8: For add and subtract, the operand is `imm[7:0]` when `op_imm`=1 and the selected source byte register when `op_imm`=0.
- R9: `illegal` is high, and no register changes, when `op_valid`=1 and any of these holds: `op_code`=3; `op_size`=3; add or subtract with `op_size`!=0; a byte access whose destination register, or whose register source (when `op_imm`=0), is numbered 4..7.
- R10: Writes land on the rising clock edge. The read ports are combinational, show the old value before that edge and the new value after it. With `op_valid`=0 no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 move, 1 byte add, 2 byte subtract, 3 reserved |
| op_size | input | 2 | 0 byte, 1 word, 2 double word, 3 reserved |
| op_imm | input | 1 | Operand comes from `imm` instead of the source register |
| src_reg | input | 3 | Source register number |
| src_hi | input | 1 | Byte source uses bits 15:8 |
| dst_reg | input | 3 | Destination register number |
| dst_hi | input | 1 | Byte destination uses bits 15:8 |
| imm | input | 32 | Immediate value |
| rd_a_sel | input | 3 | Read port A register number |
| rd_a_data | output | 32 | Read port A value |
| rd_b_sel | input | 3 | Read port B register number |
| rd_b_data | output | 32 | Read port B value |
| illegal | output | 1 | Current operation is rejected |

## Verification
The hardest case to reach from the ports is a carry or borrow that must stay inside a high byte while the other bits of the register hold distinctive data. A leak into bit 16 shows only if bits 31:16 are non-zero and the high byte sits at its wrap point. The stimulus first loads every register with double-word immediates of mixed patterns. It then drives 0xFF + 1 and 0x00 - 1 into the high byte and sweeps add, subtract and move over every source and destination pairing. After each operation all eight registers are read back through both ports.

// File: rtl/regalias_core.sv
module regalias_core #(
  parameter int NREG   = 8,
  parameter int NALIAS = 4,
  localparam int SW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [1:0]    op_size,
  input  logic          op_imm,
  input  logic [SW-1:0] src_reg,
  input  logic          src_hi,
  input  logic [SW-1:0] dst_reg,
  input  logic          dst_hi,
  input  logic [31:0]   imm,
  input  logic [SW-1:0] rd_a_sel,
  output logic [31:0]   rd_a_data,
  input  logic [SW-1:0] rd_b_sel,
  output logic [31:0]   rd_b_data,
  output logic          illegal
);
  logic [NREG-1:0][31:0] rf;
  logic [31:0] src_word, dst_word, src_f, opnd, res, merged;
  logic [7:0]  dst_byte, sum8, dif8;
  logic        byte_op, bad_dst, bad_src, we;

  assign src_word = rf[src_reg];
  assign dst_word = rf[dst_reg];
  assign dst_byte = dst_hi ? dst_word[15:8] : dst_word[7:0];

  always_comb begin
    case (op_size)
      2'd0:    src_f = {24'h0, src_hi ? src_word[15:8] : src_word[7:0]};
      2'd1:    src_f = {16'h0, src_word[15:0]};
      default: src_f = src_word;
    endcase
  end

  assign opnd = op_imm ? imm : src_f;
  assign sum8 = dst_byte + opnd[7:0];
  assign dif8 = dst_byte - opnd[7:0];

  always_comb begin
    case (op_code)
      2'd1:    res = {24'h0, sum8};
      2'd2:    res = {24'h0, dif8};
      default: res = opnd;
    endcase
  end

  always_comb begin
    case (op_size)
      2'd0:    merged = dst_hi ? {dst_word[31:16], res[7:0], dst_word[7:0]}
                               : {dst_word[31:8], res[7:0]};
      2'd1:    merged = {dst_word[31:16], res[15:0]};
      default: merged = res;
    endcase
  end

  assign byte_op = (op_size == 2'd0);
  assign bad_dst = byte_op && (int'(dst_reg) >= NALIAS);
  assign bad_src = byte_op && !op_imm && (int'(src_reg) >= NALIAS);
  assign illegal = op_valid && ((op_code == 2'd3) || (op_size == 2'd3) ||
                   (op_code != 2'd0 && !byte_op) || bad_dst || bad_src);
  assign we = op_valid && !illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) rf <= '0;
    else if (we) rf[dst_reg] <= merged;
  end

  assign rd_a_data = rf[rd_a_sel];
  assign rd_b_data = rf[rd_b_sel];
endmodule

module regalias_core_chk #(
  parameter int NREG = 8,
  parameter int SW   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_valid,
  input logic [1:0]            op_code,
  input logic [1:0]            op_size,
  input logic                  op_imm,
  input logic [SW-1:0]         dst_reg,
  input logic                  dst_hi,
  input logic [31:0]           imm,
  input logic                  illegal,
  input logic [NREG-1:0][31:0] rf
);
  assert_illegal_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(rf));

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_size == 2'd0 && dst_reg[SW-1]) |-> illegal);

  assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(rf));

  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !illegal && op_size == 2'd0) |=>
      rf[$past(dst_reg)][31:16] == $past(rf[dst_reg][31:16]));

  assert_byte_sibling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !illegal && op_size == 2'd0) |=>
      ($past(dst_hi) ? rf[$past(dst_reg)][7:0]  == $past(rf[dst_reg][7:0])
                     : rf[$past(dst_reg)][15:8] == $past(rf[dst_reg][15:8])));

  assert_word_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !illegal && op_size == 2'd1) |=>
      rf[$past(dst_reg)][31:16] == $past(rf[dst_reg][31:16]));

  assert_add_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !illegal && op_code == 2'd1 && op_imm && !dst_hi) |=>
      rf[$past(dst_reg)][7:0] == 8'($past(rf[dst_reg][7:0]) + $past(imm[7:0])));
endmodule

bind regalias_core regalias_core_chk #(.NREG(NREG), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_size(op_size), .op_imm(op_imm), .dst_reg(dst_reg), .dst_hi(dst_hi),
  .imm(imm), .illegal(illegal), .rf(rf));

// File: tb/sim_regalias_core.sv
module sim_regalias_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, op_valid = 0, op_imm = 0, src_hi = 0, dst_hi = 0;
  logic [1:0]  op_code = 0, op_size = 0;
  logic [2:0]  src_reg = 0, dst_reg = 0, rd_a_sel = 0, rd_b_sel = 0;
  logic [31:0] imm = 0, rd_a_data, rd_b_data;
  logic        illegal;

  logic [31:0] model [8];
  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  regalias_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_size(op_size), .op_imm(op_imm), .src_reg(src_reg), .src_hi(src_hi),
    .dst_reg(dst_reg), .dst_hi(dst_hi), .imm(imm), .rd_a_sel(rd_a_sel),
    .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .illegal(illegal));

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] field(input logic [31:0] v, input int sz, input bit hi);
    if (sz == 0) return (v >> (hi ? 8 : 0)) & 32'hFF;
    if (sz == 1) return v & 32'hFFFF;
    return v;
  endfunction

  task automatic readback(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_a_sel = 3'(i);
      rd_b_sel = 3'(7 - i);
      #1;
      check(rd_a_data == model[i], tag, rd_a_data, model[i]);
      check(rd_b_data == model[7 - i], tag, rd_b_data, model[7 - i]);
    end
  endtask

  task automatic apply(input int code, input int sz, input bit use_imm, input int s, input bit shi,
                       input int d, input bit dhi, input logic [31:0] iv, input string tag);
    logic [31:0] b, r, mask, old;
    int sh;
    bit bad;
    @(negedge clk);
    op_valid = 1; op_code = 2'(code); op_size = 2'(sz); op_imm = use_imm;
    src_reg = 3'(s); src_hi = shi; dst_reg = 3'(d); dst_hi = dhi; imm = iv;
    rd_a_sel = 3'(d);
    #1;
    bad = (code == 3) || (sz == 3) || (code != 0 && sz != 0) ||
          (sz == 0 && (d >= 4 || (!use_imm && s >= 4)));
    check(illegal == bad, "R9 flag", 32'(illegal), 32'(bad));
    check(rd_a_data == model[d], "R10 before edge", rd_a_data, model[d]);
    old = model[d];
    b = use_imm ? field(iv, sz == 3 ? 2 : sz, 0) : field(model[s], sz, shi);
    if (code == 1) r = (field(old, 0, dhi) + b) % 256;
    else if (code == 2) r = (field(old, 0, dhi) + 256 - b) % 256;
    else r = b;
    sh = dhi ? 8 : 0;
    mask = (sz == 0) ? (32'hFF << sh) : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (sz == 0) r = r << sh;
    if (!bad) model[d] = (old & ~mask) | (r & mask);
    @(negedge clk);
    op_valid = 0;
    readback(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    readback("R1 reset");

    for (int d = 0; d < 8; d++) apply(0, 2, 1, 0, 0, d, 0, rnd() | 32'h0101_0000, "R4 dword imm");
    for (int d = 0; d < 8; d++) apply(0, 1, 1, 0, 0, d, 0, rnd(), "R3 word imm");
    for (int d = 0; d < 4; d++)
      for (int h = 0; h < 2; h++) apply(0, 0, 1, 0, 0, d, h[0], rnd(), "R2 byte imm");

    apply(0, 0, 1, 0, 0, 0, 0, 32'd54, "R2 decimal");
    apply(0, 0, 1, 0, 0, 1, 0, 32'h36, "R2 hex");
    apply(0, 0, 1, 0, 0, 2, 0, 32'("6"), "R2 ascii");
    check(model[0][7:0] == model[1][7:0] && model[1][7:0] == model[2][7:0],
          "R2 forms agree", model[0], model[2]);

    apply(0, 0, 1, 0, 0, 3, 1, 32'hFF, "R6 setup");
    apply(1, 0, 1, 0, 0, 3, 1, 32'h01, "R6 high byte carry");
    apply(2, 0, 1, 0, 0, 3, 1, 32'h01, "R7 high byte borrow");
    apply(0, 0, 1, 0, 0, 3, 0, 32'hFF, "R6 setup");
    apply(1, 0, 1, 0, 0, 3, 0, 32'h02, "R6 low byte carry");
    apply(2, 0, 1, 0, 0, 3, 0, 32'h05, "R7 low byte borrow");

    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        apply(0, 2, 0, s, 0, d, 0, rnd(), "R5 dword move");
        apply(0, 1, 0, s, 0, d, 0, rnd(), "R5 word move");
        apply(0, 2, 1, 0, 0, d, 0, rnd(), "R4 refill");
        for (int hs = 0; hs < 2; hs++)
          for (int hd = 0; hd < 2; hd++) begin
            apply(0, 0, 0, s, hs[0], d, hd[0], rnd(), "R5 byte move");
            apply(1, 0, 0, s, hs[0], d, hd[0], rnd(), "R8 add reg");
            apply(2, 0, 0, s, hs[0], d, hd[0], rnd(), "R8 sub reg");
            apply(1, 0, 1, s, hs[0], d, hd[0], rnd(), "R6 add imm");
            apply(2, 0, 1, s, hs[0], d, hd[0], rnd(), "R7 sub imm");
          end
      end

    for (int d = 0; d < 8; d++) begin
      apply(3, 0, 1, 0, 0, d, 0, rnd(), "R9 reserved op");
      apply(0, 3, 1, 0, 0, d, 0, rnd(), "R9 reserved size");
      apply(1, 1, 1, 0, 0, d, 0, rnd(), "R9 wide add");
      apply(2, 2, 1, 0, 0, d, 0, rnd(), "R9 wide sub");
    end

    @(negedge clk);
    op_valid = 0; op_code = 0; op_size = 2; op_imm = 1; dst_reg = 5; imm = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    readback("R10 idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule